// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Framer

The framer sits between an instruction fetch stream and a decoder. It accepts 16-bit instruction parcels in program order over a valid/ready handshake. It reads the low bits of each instruction's first parcel to learn how many parcels belong to that instruction, collects them, and presents the finished instruction on a registered output with a parcel count.

Instructions of one to four parcels (16, 32, 48 and 64 bits) come out with their full payload. Parcels are packed little-end first, so the first parcel sits in bits [15:0]. Instructions of 80 to 176 bits are counted through to their last parcel and reported with an oversize flag. Only their first parcel is kept. The one length encoding reserved for 192 bits and beyond is not framed: the framer raises an error pulse and drops that parcel.

A synchronous flush throws away a partly collected instruction, so the stream can restart at a new fetch point. An instruction already waiting at the output is not affected by flush.

Top module: `parcel_framer`

## Requirements
- R1: A first parcel whose bits [1:0] are not 2'b11 is a complete instruction. It is output with out_nparc=1, out_oversize=0 and out_data equal to the parcel zero-extended.
- R2: A first parcel with bits [1:0]=2'b11 and bits [4:2]≠3'b111 starts a two-parcel instruction. It is output with out_nparc=2 and out_data={second, first} zero-extended.
- R3: A first parcel with bits [5:0]=6'b011111 starts a three-parcel instruction. It is output with out_nparc=3 and out_data={third, second, first} zero-extended.
- R4: A first parcel with bits [6:0]=7'b0111111 starts a four-parcel instruction. It is output with out_nparc=4 and out_data={fourth, third, second, first}.
- R5: A first parcel with bits [6:0]=7'b1111111 and field k=bits [14:12] in 0..6 starts an instruction of 5+k parcels. All of its parcels are accepted. It is output once with out_nparc=5+k, out_oversize=1 and out_data equal to the first parcel zero-extended.
- R6: A first parcel with bits [6:0]=7'b1111111 and bits [14:12]=3'b111 produces no output. rsv_err is high for the one cycle after that parcel is accepted, and the next accepted parcel is treated as a first parcel.
- R7: While out_valid is high and out_ready is low, in_ready is low and the output fields (out_data, out_nparc, out_oversize) stay unchanged.
- R8: While flush is high, any partly collected instruction is abandoned and a parcel accepted in that cycle is discarded. The next accepted parcel is a first parcel.
- R9: After reset, out_valid and rsv_err are low and in_ready is high.
- R10: The instruction is presented in the cycle after its final parcel is accepted. out_oversize is high exactly when out_nparc exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Abandon partial instruction, drop parcel this cycle |
| in_valid | input | 1 | Parcel offered |
| in_parcel | input | 16 | Instruction parcel |
| in_ready | output | 1 | Parcel will be taken at this edge |
| out_valid | output | 1 | Completed instruction held |
| out_ready | input | 1 | Consumer takes the instruction |
| out_data | output | 64 | Packed payload, first parcel lowest |
| out_nparc | output | 4 | Instruction length in parcels, 1..11 |
| out_oversize | output | 1 | Length above four parcels, payload dropped |
| rsv_err | output | 1 | Reserved length encoding seen |

## Verification
A wrong parcel counter shows up at the ports as a misframed stream. An output arrives early or late, carries a neighbour's parcel in the wrong slot, or has a wrong out_nparc. Every later instruction then goes wrong as well, so a single counting fault is seen on the very next output transfer. A stale busy state after flush turns the first parcel after the flush into a continuation; this is visible one cycle after the instruction should have been presented. Slot-select faults corrupt out_data for the affected length on its first occurrence. The random stream mixes all length classes, so each class is exercised many times.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
    localparam int PARCEL_W     = 16;
    localparam int KEEP_PARCELS = 4;
    localparam int NPARC_W      = 4;
    localparam int MAX_NPARC    = 11;
endpackage

// File: rtl/pfr_len_decode.sv
// Length decode from the first parcel's low bits and the long-length field.
module pfr_len_decode #(
    parameter int CW = pfr_pkg::NPARC_W
) (
    input  logic [6:0]    low7,
    input  logic [2:0]    lfield,
    output logic          rsv,
    output logic [CW-1:0] nparc
);
    always_comb begin
        rsv   = 1'b0;
        nparc = CW'(1);
        if (low7[1:0] != 2'b11) begin
            nparc = CW'(1);
        end else if (low7[4:2] != 3'b111) begin
            nparc = CW'(2);
        end else if (!low7[5]) begin
            nparc = CW'(3);
        end else if (!low7[6]) begin
            nparc = CW'(4);
        end else if (lfield == 3'b111) begin
            rsv   = 1'b1;
            nparc = '0;
        end else begin
            nparc = CW'(5) + CW'(lfield);
        end
    end
endmodule

// File: rtl/pfr_slot_buf.sv
// Next value of the parcel slots: clear on a new instruction, write one slot.
module pfr_slot_buf #(
    parameter int PW   = pfr_pkg::PARCEL_W,
    parameter int KEEP = pfr_pkg::KEEP_PARCELS,
    parameter int CW   = pfr_pkg::NPARC_W
) (
    input  logic [KEEP*PW-1:0] cur,
    input  logic               clr,
    input  logic               wr,
    input  logic [CW-1:0]      widx,
    input  logic [PW-1:0]      din,
    output logic [KEEP*PW-1:0] nxt
);
    for (genvar g = 0; g < KEEP; g++) begin : g_slot
        assign nxt[g*PW +: PW] = (wr && widx == CW'(g)) ? din
                               : (clr ? '0 : cur[g*PW +: PW]);
    end
endmodule

// File: rtl/parcel_framer.sv
module parcel_framer #(
    parameter int PW   = pfr_pkg::PARCEL_W,
    parameter int KEEP = pfr_pkg::KEEP_PARCELS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [PW-1:0]      in_parcel,
    output logic               in_ready,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PW*KEEP-1:0] out_data,
    output logic [3:0]         out_nparc,
    output logic               out_oversize,
    output logic               rsv_err
);
    localparam int DW = PW * KEEP;
    localparam int CW = pfr_pkg::NPARC_W;
    localparam logic [CW-1:0] KEEP_C = CW'(KEEP);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
        logic [CW-1:0] idx;
        logic [CW-1:0] total;
        logic [DW-1:0] slots;
        logic          ov;
        logic [DW-1:0] odata;
        logic [CW-1:0] onparc;
        logic          oover;
        logic          err;
    } st_t;

    st_t s_q, s_d;

    logic          acc, take, hd_rsv, wr, clr, complete;
    logic [CW-1:0] hd_n, widx, tot_eff;
    logic [DW-1:0] slot_nxt;

    assign in_ready = !s_q.ov || out_ready;
    assign acc      = in_valid && in_ready;
    assign take     = acc && !flush;

    pfr_len_decode #(.CW(CW)) u_dec (
        .low7  (in_parcel[6:0]),
        .lfield(in_parcel[14:12]),
        .rsv   (hd_rsv),
        .nparc (hd_n)
    );

    assign clr  = take && !s_q.busy;
    assign widx = s_q.busy ? s_q.idx : '0;
    assign wr   = take && (s_q.busy ? (s_q.idx < KEEP_C && s_q.total <= KEEP_C)
                                    : !hd_rsv);

    pfr_slot_buf #(.PW(PW), .KEEP(KEEP), .CW(CW)) u_slots (
        .cur (s_q.slots),
        .clr (clr),
        .wr  (wr),
        .widx(widx),
        .din (in_parcel),
        .nxt (slot_nxt)
    );

    assign tot_eff = s_q.busy ? s_q.total : hd_n;

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.slots = slot_nxt;
        complete  = 1'b0;
        if (s_q.ov && out_ready) begin
            s_d.ov = 1'b0;
        end
        if (flush) begin
            s_d.busy = 1'b0;
        end else if (acc) begin
            if (!s_q.busy) begin
                if (hd_rsv) begin
                    s_d.err = 1'b1;
                end else if (hd_n == CW'(1)) begin
                    complete = 1'b1;
                end else begin
                    s_d.busy  = 1'b1;
                    s_d.left  = hd_n - CW'(1);
                    s_d.idx   = CW'(1);
                    s_d.total = hd_n;
                end
            end else begin
                s_d.idx  = s_q.idx + CW'(1);
                s_d.left = s_q.left - CW'(1);
                if (s_q.left == CW'(1)) begin
                    s_d.busy = 1'b0;
                    complete = 1'b1;
                end
            end
        end
        if (complete) begin
            s_d.ov     = 1'b1;
            s_d.odata  = slot_nxt;
            s_d.onparc = tot_eff;
            s_d.oover  = tot_eff > KEEP_C;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid    = s_q.ov;
    assign out_data     = s_q.odata;
    assign out_nparc    = s_q.onparc;
    assign out_oversize = s_q.oover;
    assign rsv_err      = s_q.err;
endmodule

// File: rtl/pfr_checker.sv
module pfr_checker #(
    parameter int PW   = 16,
    parameter int KEEP = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [PW*KEEP-1:0] out_data,
    input logic [3:0]         out_nparc,
    input logic               out_oversize,
    input logic               rsv_err
);
    a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_nparc) && $stable(out_oversize)));

    a_r10_length_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nparc >= 4'd1 && out_nparc <= 4'd11
            && out_oversize == (out_nparc > 4'(KEEP))));

    a_r5_oversize_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_oversize) |-> (out_data[PW*KEEP-1:PW] == '0));

    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |-> $past(in_valid && in_ready && !flush));

    a_r6_err_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_err |-> !$rose(out_valid));

    a_r8_flush_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rsv_err);
endmodule

bind parcel_framer pfr_checker #(.PW(PW), .KEEP(KEEP)) u_pfr_chk (.*);

// File: tb/tb_parcel_framer.sv
module tb_parcel_framer;
    logic        clk = 1'b0;
    logic        rst_n, flush, in_valid, out_ready;
    logic [15:0] in_parcel;
    logic        in_ready, out_valid, out_oversize, rsv_err;
    logic [63:0] out_data;
    logic [3:0]  out_nparc;

    always #10 clk = ~clk;

    parcel_framer dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_parcel(in_parcel), .in_ready(in_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_nparc(out_nparc),
        .out_oversize(out_oversize), .rsv_err(rsv_err)
    );

    int errors = 0;
    int checks = 0;

    logic [15:0] par   [0:4095];
    bit          rhead [0:4095];
    logic [63:0] e_data[0:1023];
    int          e_np  [0:1023];
    int npar = 0;
    int nexp = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string tag(input int np);
        case (np)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Build one instruction of the chosen class; expected values follow the requirements.
    task automatic gen(input int kind);
        logic [15:0] h;
        logic [63:0] d;
        int n, k;
        h = 16'($urandom());
        k = $urandom_range(0, 6);
        case (kind)
            0: begin h[1:0] = 2'($urandom_range(0, 2)); n = 1; end
            1: begin h[1:0] = 2'b11; h[4:2] = 3'($urandom_range(0, 6)); n = 2; end
            2: begin h[5:0] = 6'b011111; n = 3; end
            3: begin h[6:0] = 7'b0111111; n = 4; end
            4: begin h[6:0] = 7'h7f; h[14:12] = 3'(k); n = 5 + k; end
            default: begin h[6:0] = 7'h7f; h[14:12] = 3'b111; n = 1; end
        endcase
        par[npar] = h;
        rhead[npar] = (kind == 5);
        d = 64'(h);
        npar++;
        for (int i = 1; i < n; i++) begin
            par[npar] = 16'($urandom());
            rhead[npar] = 1'b0;
            if (n <= 4) d[i*16 +: 16] = par[npar];
            npar++;
        end
        if (kind != 5) begin
            e_data[nexp] = d;
            e_np[nexp] = n;
            nexp++;
        end
    endtask

    initial begin
        int pi, oi, cyc, sn;
        bit exp_err, stalled;
        logic [63:0] sd;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_parcel = '0; out_ready = 1'b0;
        for (int i = 0; i < 300; i++) gen($urandom_range(0, 5));

        repeat (3) @(negedge clk);
        #5;
        chk(!out_valid, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(!rsv_err, "R9", "rsv_err in reset", 64'(rsv_err), 64'd0);
        chk(in_ready, "R9", "in_ready in reset", 64'(in_ready), 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(!out_valid && in_ready, "R9", "idle after reset", 64'(out_valid), 64'd0);

        // Random stream
        pi = 0; oi = 0; cyc = 0; exp_err = 0; stalled = 0; sd = '0; sn = 0;
        while ((pi < npar || oi < nexp) && cyc < 100000) begin
            @(negedge clk);
            cyc++;
            in_valid  = (pi < npar) && ($urandom_range(0, 9) < 7);
            in_parcel = (pi < npar) ? par[pi] : 16'h0;
            out_ready = (pi >= npar) ? 1'b1 : ($urandom_range(0, 9) < 6);
            #5;
            if (rsv_err || exp_err)
                chk(rsv_err == exp_err, "R6", "rsv_err pulse", 64'(rsv_err), 64'(exp_err));
            exp_err = 0;
            if (stalled)
                chk(out_valid && out_data == sd && 32'(out_nparc) == sn, "R7",
                    "held output changed", out_data, sd);
            stalled = 0;
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R7", "in_ready while held", 64'(in_ready), 64'd0);
                stalled = 1; sd = out_data; sn = 32'(out_nparc);
            end
            if (out_valid && out_ready) begin
                if (oi < nexp) begin
                    chk(out_data == e_data[oi], tag(e_np[oi]), "out_data", out_data, e_data[oi]);
                    chk(32'(out_nparc) == e_np[oi], tag(e_np[oi]), "out_nparc R10",
                        64'(out_nparc), 64'(e_np[oi]));
                    chk(out_oversize == (e_np[oi] > 4), "R10", "out_oversize",
                        64'(out_oversize), 64'(e_np[oi] > 4));
                    oi++;
                end else begin
                    chk(1'b0, "R10", "unexpected output", out_data, 64'd0);
                end
            end
            if (in_valid && in_ready) begin
                if (rhead[pi]) exp_err = 1;
                pi++;
            end
        end
        if (cyc >= 100000) chk(1'b0, "R10", "watchdog expired", 64'(oi), 64'(nexp));
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        #5;
        chk(rsv_err == exp_err, "R6", "final rsv_err", 64'(rsv_err), 64'(exp_err));

        // R8: flush drops partial 32-bit instruction and the parcel in the flush cycle
        @(negedge clk);
        in_valid = 1'b1; in_parcel = 16'h0003; #5;
        @(negedge clk);
        in_parcel = 16'h1234; flush = 1'b1; #5;
        chk(!out_valid, "R8", "no output in flush", 64'(out_valid), 64'd0);
        @(negedge clk);
        flush = 1'b0; in_parcel = 16'hABC0; #5;
        chk(!out_valid, "R8", "flush-cycle parcel not framed", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid = 1'b0; #5;
        chk(out_valid && out_data == 64'hABC0 && out_nparc == 4'd1, "R8",
            "first parcel after flush", out_data, 64'hABC0);

        // R6: reserved head, then a 16-bit instruction
        @(negedge clk);
        in_valid = 1'b1; in_parcel = 16'h707F; #5;
        @(negedge clk);
        in_parcel = 16'h0001; #5;
        chk(rsv_err && !out_valid, "R6", "reserved head flagged", 64'(rsv_err), 64'd1);
        @(negedge clk);
        in_valid = 1'b0; #5;
        chk(out_valid && out_data == 64'h1 && out_nparc == 4'd1 && !rsv_err, "R6",
            "resume after reserved", out_data, 64'h1);

        // R7: stalled output blocks input
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_parcel = 16'h0002; #5;
        @(negedge clk);
        in_parcel = 16'h0006; #5;
        chk(out_valid && !in_ready && out_data == 64'h2, "R7", "stall holds",
            out_data, 64'h2);
        @(negedge clk);
        out_ready = 1'b1; #5;
        chk(in_ready, "R7", "ready with consumer", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0; #5;
        chk(out_valid && out_data == 64'h6, "R1", "next 16-bit after stall", out_data, 64'h6);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule